// File: doc/BRIEF.md
# Clock Mode Decoder and Output Divider

This block is the digital control stage of a multi-output clock generator. A fast source clock, running at twice the host clock rate, feeds a phase counter that produces the host clock and a bus clock. The bus clock is the host clock divided by 3, 4 or 6. Two further clocks pass through the block under the control of glitch-free gates: a 48 MHz clock and a reference clock. A separate test clock can replace all of them. A 3-bit mode word sets the host rate, the bus ratio, which outputs are disabled, an all-high-impedance state and the test mode. The block also reports the host rate it decoded, so that the upstream frequency synthesizer can be steered.

Each output has its own output-enable flag, which the pad ring uses for high-impedance control. An active-low power-down pin forces the outputs at once and without a clock. The block records the release of power-down in the source clock domain and then restarts its dividers from phase zero. A mode change in the source clock domain waits for the end of a bus-clock period, where both counter-driven outputs are low.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: While reset is asserted, every output-enable flag is low and the host, bus, 48 MHz and reference outputs are low. host_rate reads 0.
- R2: mode_sel sets which outputs toggle. 000 runs all four outputs. 001 stops the 48 MHz output. 010 stops the 48 MHz output and the bus clock. 100 and 110 run all four. 101 stops the 48 MHz output. A stopped output is held low while its enable stays high.
- R3: host_p toggles at half the source clock rate. The bus clock is host_p divided by 3 in modes 000/001/010, by 4 in 100/101 and by 6 in 110. Each bus rising edge coincides with a host rising edge.
- R4: In every normal mode the bus clock is high for half of its period, which is within the 45/55 duty-cycle limit.
- R5: In mode 011 all six output-enable flags are low and no output toggles.
- R6: In mode 111 host_p and usb_clk run at clk_test/2, bus_clk runs at clk_test/8 and ref_clk follows clk_test. All enables are high in this mode.
- R7: host_rate reports the decoded host rate. The code is 0 for modes 000/001/010/011, 1 for 100/101, 2 for 110 and 3 for 111.
- R8: While pwr_dn_n is low, with no clock edge needed, host_p is high, host_n_oe is low, host_p_oe stays high, and bus_clk, usb_clk and ref_clk are low.
- R9: After pwr_dn_n rises, all outputs stay low until the dividers restart. The first bus rising edge then coincides with a host rising edge, and the normal rates resume.
- R10: A change between normal modes takes effect only at the end of a bus period. No bus high or low pulse is shorter than the shortest half period of the old mode or the new one.
- R11: Whenever host_n_oe is high, host_n is the complement of host_p.
- R12: Mode 011 keeps every output enable low even while power-down is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock at twice the host rate |
| clk_test | input | 1 | Test clock used in mode 111 |
| clk48_in | input | 1 | Ideal 48 MHz clock to be gated |
| ref_in | input | 1 | Ideal reference clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode word |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| host_p | output | 1 | Host clock, true side |
| host_n | output | 1 | Host clock, complement side |
| host_p_oe | output | 1 | Enable for host_p |
| host_n_oe | output | 1 | Enable for host_n |
| bus_clk | output | 1 | Divided bus clock |
| bus_oe | output | 1 | Enable for bus_clk |
| usb_clk | output | 1 | Gated 48 MHz clock |
| usb_oe | output | 1 | Enable for usb_clk |
| ref_clk | output | 1 | Gated reference clock |
| ref_oe | output | 1 | Enable for ref_clk |
| host_rate | output | 2 | Decoded host rate code |

## Verification
The bench steps through all eight modes and counts edges on every output over a fixed window. A wrong decode shows up as a wrong divide ratio or as a 48 MHz or bus output that toggles when it should be held low. It changes mode several times in the middle of a bus period while it records the shortest high and low runs of the bus clock. A design that switches at once, instead of at the end of the period, leaves a one-cycle sliver there. Power-down is checked one nanosecond after the pin falls, which exposes a design that waits for a clock edge before forcing the outputs. On release, the bench checks that the first bus edge lands on a host edge; a divider that resumes from a stale phase breaks that alignment. The bench also asserts power-down while mode 011 is active, to catch a power-down path that turns the host enable back on.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    RATE_100  = 2'd0,
    RATE_133  = 2'd1,
    RATE_200  = 2'd2,
    RATE_TEST = 2'd3
  } rate_e;

  typedef struct packed {
    logic  normal;
    logic  hiz;
    logic  test;
    logic  bus_en;
    logic  usb_en;
    logic  ref_en;
    rate_e rate;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [2:0] m);
    mode_cfg_t c;
    c = '0;
    c.rate = RATE_100;
    case (m)
      3'b000: begin c.normal = 1'b1; c.bus_en = 1'b1; c.usb_en = 1'b1; c.ref_en = 1'b1; end
      3'b001: begin c.normal = 1'b1; c.bus_en = 1'b1; c.ref_en = 1'b1; end
      3'b010: begin c.normal = 1'b1; c.ref_en = 1'b1; end
      3'b011: begin c.hiz = 1'b1; end
      3'b100: begin c.normal = 1'b1; c.bus_en = 1'b1; c.usb_en = 1'b1; c.ref_en = 1'b1;
                    c.rate = RATE_133; end
      3'b101: begin c.normal = 1'b1; c.bus_en = 1'b1; c.ref_en = 1'b1; c.rate = RATE_133; end
      3'b110: begin c.normal = 1'b1; c.bus_en = 1'b1; c.usb_en = 1'b1; c.ref_en = 1'b1;
                    c.rate = RATE_200; end
      default: begin c.test = 1'b1; c.rate = RATE_TEST; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= '0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en_req,
  output logic clk_out
);

  logic g_rst_n;
  logic en_s;
  logic en_lo;

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rst_sync (
    .clk(clk_in), .rst_n(rst_n), .d(1'b1), .q(g_rst_n)
  );

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(1)) u_en_sync (
    .clk(clk_in), .rst_n(g_rst_n), .d(en_req), .q(en_s)
  );

  // Enable moves only while the gated clock is low.
  always_ff @(negedge clk_in or negedge g_rst_n) begin
    if (!g_rst_n) en_lo <= 1'b0;
    else          en_lo <= en_s;
  end

  assign clk_out = clk_in & en_lo;

endmodule

// File: rtl/clkgen_test_div.sv
module clkgen_test_div #(
  parameter int SYNC_STAGES   = 2,
  parameter int TEST_DIV_LOG2 = 3
) (
  input  logic clk_test,
  input  logic rst_n,
  input  logic test_req,
  output logic t_half,
  output logic t_slow,
  output logic t_ref
);

  logic                     t_rst_n;
  logic                     t_on;
  logic [TEST_DIV_LOG2-1:0] cnt_q;
  logic [TEST_DIV_LOG2-1:0] cnt_d;

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rst_sync (
    .clk(clk_test), .rst_n(rst_n), .d(1'b1), .q(t_rst_n)
  );

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(1)) u_on_sync (
    .clk(clk_test), .rst_n(t_rst_n), .d(test_req), .q(t_on)
  );

  always_comb begin
    cnt_d = t_on ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_test or negedge t_rst_n) begin
    if (!t_rst_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign t_half = cnt_q[0];
  assign t_slow = cnt_q[TEST_DIV_LOG2-1];

  clkgen_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ref_gate (
    .clk_in(clk_test), .rst_n(rst_n), .en_req(test_req), .clk_out(t_ref)
  );

  // R6: once running, the half-rate test output changes on every test edge
  a_r6_half_toggles: assert property (@(posedge clk_test) disable iff (!t_rst_n)
    $past(t_on) |-> (t_half != $past(t_half)));

endmodule

// File: rtl/clkgen_core.sv
module clkgen_core
  import clkgen_pkg::*;
#(
  parameter int RATIO_LO  = 3,
  parameter int RATIO_MID = 4,
  parameter int RATIO_HI  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_s,
  input  logic       pd_s,
  output logic       host_q,
  output logic       bus_q,
  output logic       usb_en,
  output logic       ref_en,
  output logic       test_q,
  output logic       hiz_q,
  output logic [1:0] host_rate
);

  localparam int PH_W = $clog2(2 * RATIO_HI);

  function automatic logic [PH_W-1:0] half_of(input rate_e r);
    case (r)
      RATE_133: return PH_W'(RATIO_MID);
      RATE_200: return PH_W'(RATIO_HI);
      default:  return PH_W'(RATIO_LO);
    endcase
  endfunction

  logic [2:0]      cur_mode, mode_nx;
  logic [PH_W-1:0] ph, ph_nx;
  logic            run_q, run_nx;
  logic            host_nx, bus_nx, usb_nx, ref_nx, test_nx, hiz_nx;
  logic            apply;
  logic [PH_W-1:0] n_cur, n_nx, last_cur;
  mode_cfg_t       cfg_cur, cfg_nx;

  always_comb begin
    cfg_cur  = decode_mode(cur_mode);
    n_cur    = half_of(cfg_cur.rate);
    last_cur = (n_cur << 1) - 1'b1;
    // A new mode lands only at the end of a bus period or while idle.
    apply    = (mode_s != cur_mode) && (!run_q || (ph == last_cur));
    mode_nx  = apply ? mode_s : cur_mode;
    cfg_nx   = decode_mode(mode_nx);
    n_nx     = half_of(cfg_nx.rate);
    run_nx   = cfg_nx.normal && !pd_s;
    if (!run_nx || apply || !run_q || (ph == last_cur)) ph_nx = '0;
    else                                                ph_nx = ph + 1'b1;
    host_nx  = run_nx && !ph_nx[0];
    bus_nx   = run_nx && cfg_nx.bus_en && (ph_nx < n_nx);
    usb_nx   = cfg_nx.usb_en && !pd_s;
    ref_nx   = cfg_nx.ref_en && !pd_s;
    test_nx  = cfg_nx.test && !pd_s;
    hiz_nx   = cfg_nx.hiz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode <= 3'b011;
      ph       <= '0;
      run_q    <= 1'b0;
      host_q   <= 1'b0;
      bus_q    <= 1'b0;
      usb_en   <= 1'b0;
      ref_en   <= 1'b0;
      test_q   <= 1'b0;
      hiz_q    <= 1'b1;
    end else begin
      cur_mode <= mode_nx;
      ph       <= ph_nx;
      run_q    <= run_nx;
      host_q   <= host_nx;
      bus_q    <= bus_nx;
      usb_en   <= usb_nx;
      ref_en   <= ref_nx;
      test_q   <= test_nx;
      hiz_q    <= hiz_nx;
    end
  end

  assign host_rate = cfg_cur.rate;

  // R10: the applied mode changes only after a cycle with both outputs low
  a_r10_safe_switch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mode) |-> (!$past(host_q) && !$past(bus_q)));

  // R3: every bus rising edge coincides with a host rising edge
  a_r3_edges_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_q) |-> $rose(host_q));

  // R5: high-impedance mode leaves all counter and gate requests idle
  a_r5_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_q |-> (!host_q && !bus_q && !usb_en && !ref_en && !test_q));

  // R8: power-down stops every path one cycle after it is seen
  a_r8_pd_stops: assert property (@(posedge clk) disable iff (!rst_n)
    pd_s |=> (!host_q && !bus_q && !usb_en && !ref_en && !test_q));

  // R6: the normal divider is silent while the test path owns the outputs
  a_r6_test_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |-> (!host_q && !bus_q && !hiz_q));

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl #(
  parameter int SYNC_STAGES   = 2,
  parameter int RATIO_LO      = 3,
  parameter int RATIO_MID     = 4,
  parameter int RATIO_HI      = 6,
  parameter int TEST_DIV_LOG2 = 3
) (
  input  logic       clk_src,
  input  logic       clk_test,
  input  logic       clk48_in,
  input  logic       ref_in,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       pwr_dn_n,
  output logic       host_p,
  output logic       host_n,
  output logic       host_p_oe,
  output logic       host_n_oe,
  output logic       bus_clk,
  output logic       bus_oe,
  output logic       usb_clk,
  output logic       usb_oe,
  output logic       ref_clk,
  output logic       ref_oe,
  output logic [1:0] host_rate
);

  localparam int N_GATED = 2;

  logic       core_rst_n;
  logic [2:0] mode_s;
  logic       pdn_s;
  logic       host_q, bus_q, usb_en, ref_en, test_q, hiz_q;
  logic       t_half, t_slow, t_ref;
  logic       pd_pin, host_val;
  logic [N_GATED-1:0] g_clk, g_en, g_out;

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rst_sync (
    .clk(clk_src), .rst_n(rst_n), .d(1'b1), .q(core_rst_n)
  );

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(3)) u_mode_sync (
    .clk(clk_src), .rst_n(core_rst_n), .d(mode_sel), .q(mode_s)
  );

  clkgen_sync #(.STAGES(SYNC_STAGES), .W(1)) u_pd_sync (
    .clk(clk_src), .rst_n(core_rst_n), .d(pwr_dn_n), .q(pdn_s)
  );

  clkgen_core #(
    .RATIO_LO(RATIO_LO), .RATIO_MID(RATIO_MID), .RATIO_HI(RATIO_HI)
  ) u_core (
    .clk(clk_src), .rst_n(core_rst_n), .mode_s(mode_s), .pd_s(!pdn_s),
    .host_q(host_q), .bus_q(bus_q), .usb_en(usb_en), .ref_en(ref_en),
    .test_q(test_q), .hiz_q(hiz_q), .host_rate(host_rate)
  );

  assign g_clk = {ref_in, clk48_in};
  assign g_en  = {ref_en, usb_en};

  generate
    for (genvar g = 0; g < N_GATED; g++) begin : g_path
      clkgen_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk_in(g_clk[g]), .rst_n(rst_n), .en_req(g_en[g]), .clk_out(g_out[g])
      );
    end
  endgenerate

  clkgen_test_div #(
    .SYNC_STAGES(SYNC_STAGES), .TEST_DIV_LOG2(TEST_DIV_LOG2)
  ) u_test (
    .clk_test(clk_test), .rst_n(rst_n), .test_req(test_q),
    .t_half(t_half), .t_slow(t_slow), .t_ref(t_ref)
  );

  // Each source is forced low when not selected, so an OR merges them.
  assign pd_pin    = !pwr_dn_n;
  assign host_val  = host_q | t_half;
  assign host_p    = pd_pin | host_val;
  assign host_n    = !pd_pin & !host_val;
  assign bus_clk   = !pd_pin & (bus_q | t_slow);
  assign usb_clk   = !pd_pin & (g_out[0] | t_half);
  assign ref_clk   = !pd_pin & (g_out[1] | t_ref);
  assign host_p_oe = !hiz_q;
  assign host_n_oe = !hiz_q & !pd_pin;
  assign bus_oe    = !hiz_q;
  assign usb_oe    = !hiz_q;
  assign ref_oe    = !hiz_q;

endmodule

// File: tb/clkgen_mode_ctrl_tb.sv
module clkgen_mode_ctrl_tb;

  logic clk_src = 1'b0, clk_test = 1'b0, clk48_in = 1'b0, ref_in = 1'b0;
  logic rst_n, pwr_dn_n;
  logic [2:0] mode_sel;
  logic host_p, host_n, host_p_oe, host_n_oe, bus_clk, bus_oe;
  logic usb_clk, usb_oe, ref_clk, ref_oe;
  logic [1:0] host_rate;

  always #5  clk_src  = ~clk_src;
  always #6  clk_test = ~clk_test;
  always #11 clk48_in = ~clk48_in;
  always #35 ref_in   = ~ref_in;

  clkgen_mode_ctrl u_dut (
    .clk_src(clk_src), .clk_test(clk_test), .clk48_in(clk48_in), .ref_in(ref_in),
    .rst_n(rst_n), .mode_sel(mode_sel), .pwr_dn_n(pwr_dn_n),
    .host_p(host_p), .host_n(host_n), .host_p_oe(host_p_oe), .host_n_oe(host_n_oe),
    .bus_clk(bus_clk), .bus_oe(bus_oe), .usb_clk(usb_clk), .usb_oe(usb_oe),
    .ref_clk(ref_clk), .ref_oe(ref_oe), .host_rate(host_rate)
  );

  localparam int WIN = 240;
  // columns: host, bus, usb, ref edges per window; enables; rate code
  localparam int EXP_HOST [8] = '{120, 120, 120, 0, 120, 120, 120, 100};
  localparam int EXP_BUS  [8] = '{40, 40, 0, 0, 30, 30, 20, 25};
  localparam int EXP_USB  [8] = '{109, 0, 0, 0, 109, 0, 109, 100};
  localparam int EXP_REF  [8] = '{34, 34, 34, 0, 34, 34, 34, 200};
  localparam int EXP_OE   [8] = '{1, 1, 1, 0, 1, 1, 1, 1};
  localparam int EXP_RATE [8] = '{0, 0, 0, 0, 1, 1, 2, 3};

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int n_host = 0, n_bus = 0, n_usb = 0, n_ref = 0;
  int compl_err = 0;

  always @(posedge host_p)  n_host++;
  always @(posedge bus_clk) n_bus++;
  always @(posedge usb_clk) n_usb++;
  always @(posedge ref_clk) n_ref++;

  always @(negedge clk_src) if (host_n_oe && (host_n !== ~host_p)) compl_err++;

  // shortest bounded bus runs, for the switch test
  bit mon_en = 1'b0;
  logic mon_prev = 1'b0;
  bit mon_seen = 1'b0;
  int mon_run = 0, min_hi = 1000, min_lo = 1000;
  always @(negedge clk_src) begin
    if (!mon_en) begin
      mon_seen = 1'b0; mon_prev = bus_clk; mon_run = 0;
    end else if (bus_clk !== mon_prev) begin
      if (mon_seen) begin
        if (mon_prev && mon_run < min_hi) min_hi = mon_run;
        if (!mon_prev && mon_run < min_lo) min_lo = mon_run;
      end
      mon_seen = 1'b1; mon_prev = bus_clk; mon_run = 1;
    end else begin
      mon_run++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic near(input string req, input string what, input int act, input int exp);
    check((act - exp) <= 1 && (exp - act) <= 1, req, what, act, exp);
  endtask

  task automatic measure(output int h, output int b, output int u, output int r,
                         output int hi);
    int h0, b0, u0, r0;
    @(negedge clk_src);
    h0 = n_host; b0 = n_bus; u0 = n_usb; r0 = n_ref; hi = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk_src);
      if (bus_clk) hi++;
    end
    h = n_host - h0; b = n_bus - b0; u = n_usb - u0; r = n_ref - r0;
  endtask

  task automatic set_mode(input logic [2:0] m, input int settle);
    @(negedge clk_src);
    mode_sel = m;
    repeat (settle) @(negedge clk_src);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    int h, b, u, r, hi;
    rst_n = 1'b0; pwr_dn_n = 1'b1; mode_sel = 3'b000;
    repeat (4) @(negedge clk_src);
    // R1: reset state
    check({host_p_oe, host_n_oe, bus_oe, usb_oe, ref_oe} == 5'b0, "R1", "enables in reset",
          {host_p_oe, host_n_oe, bus_oe, usb_oe, ref_oe}, 0);
    check({host_p, bus_clk, usb_clk, ref_clk} == 4'b0, "R1", "outputs in reset",
          {host_p, bus_clk, usb_clk, ref_clk}, 0);
    check(host_rate == 2'd0, "R1", "rate in reset", host_rate, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk_src);

    // table walk over all modes (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 8; m++) begin
      set_mode(3'(m), 40);
      measure(h, b, u, r, hi);
      near("R3", $sformatf("mode %0d host edges", m), h, EXP_HOST[m]);
      near("R3", $sformatf("mode %0d bus edges", m), b, EXP_BUS[m]);
      near("R2", $sformatf("mode %0d usb edges", m), u, EXP_USB[m]);
      near("R2", $sformatf("mode %0d ref edges", m), r, EXP_REF[m]);
      check({host_p_oe, host_n_oe, bus_oe, usb_oe, ref_oe} ==
            (EXP_OE[m] != 0 ? 5'b11111 : 5'b00000), (m == 3) ? "R5" : "R2",
            $sformatf("mode %0d enables", m),
            {host_p_oe, host_n_oe, bus_oe, usb_oe, ref_oe}, EXP_OE[m] != 0 ? 31 : 0);
      check(int'(host_rate) == EXP_RATE[m], "R7", $sformatf("mode %0d rate code", m),
            host_rate, EXP_RATE[m]);
      if (m != 7 && EXP_BUS[m] > 0)
        check(hi >= WIN * 45 / 100 && hi <= WIN * 55 / 100, "R4",
              $sformatf("mode %0d bus high samples", m), hi, WIN / 2);
      if (m == 7) near("R6", "test ref follows test clock", r, 200);
    end

    // R10: mode switches in the middle of bus periods
    set_mode(3'b000, 40);
    @(negedge clk_src); mon_en = 1'b1;
    set_mode(3'b110, 37);
    set_mode(3'b100, 53);
    set_mode(3'b000, 29);
    set_mode(3'b101, 41);
    set_mode(3'b110, 31);
    set_mode(3'b001, 44);
    mon_en = 1'b0;
    check(min_hi >= 3, "R10", "shortest bus high run", min_hi, 3);
    check(min_lo >= 3, "R10", "shortest bus low run", min_lo, 3);

    // R8: asynchronous power-down
    set_mode(3'b000, 40);
    #2 pwr_dn_n = 1'b0;
    #1;
    check(host_p == 1'b1 && host_p_oe == 1'b1, "R8", "host true held and enabled",
          {host_p, host_p_oe}, 3);
    check(host_n_oe == 1'b0, "R8", "complement undriven", host_n_oe, 0);
    check({bus_clk, usb_clk, ref_clk} == 3'b0, "R8", "other outputs low",
          {bus_clk, usb_clk, ref_clk}, 0);
    measure(h, b, u, r, hi);
    check(h + b + u + r == 0, "R8", "edges during power-down", h + b + u + r, 0);

    // R12: high impedance wins while powered down
    set_mode(3'b011, 20);
    check({host_p_oe, host_n_oe, bus_oe, usb_oe, ref_oe} == 5'b0, "R12",
          "enables in hi-z under power-down", {host_p_oe, host_n_oe, bus_oe, usb_oe, ref_oe}, 0);
    set_mode(3'b000, 20);
    check(host_p_oe == 1'b1 && host_n_oe == 1'b0, "R8", "enables after leaving hi-z",
          {host_p_oe, host_n_oe}, 2);

    // R9: release and restart from phase zero
    @(negedge clk_src);
    pwr_dn_n = 1'b1;
    #1;
    check(host_p == 1'b0 && bus_clk == 1'b0, "R9", "outputs low right after release",
          {host_p, bus_clk}, 0);
    @(posedge bus_clk);
    #1;
    check(host_p == 1'b1, "R9", "first bus edge aligned to host", host_p, 1);
    repeat (10) @(negedge clk_src);
    measure(h, b, u, r, hi);
    near("R9", "host edges after release", h, 120);
    near("R9", "bus edges after release", b, 40);

    // R11: complement relation over the whole run
    check(compl_err == 0, "R11", "host_n mismatches", compl_err, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule